// File: doc/BRIEF.md
# Banked Content-Addressed Tag Cache

This block is a read/write cache for a processor's virtual address stream. Its tags are held in four content-addressed banks instead of an indexed tag RAM. Two address bits pick a bank. The upper address bits and the requester's privilege level are then compared against every entry of that bank in one cycle. A matching entry number, joined with the bank number and the word-in-line field, forms the address into a single shared data RAM. Within a bank any line may sit in any entry, so lines whose addresses agree in the bank bits never conflict with each other until the bank is full.

A request is accepted while the block is idle. One request is handled at a time. A read hit is answered from the data RAM. A read miss fetches the whole four-word line from a simple request/acknowledge memory port, installs it and returns the requested word. Stores always go to memory. A store also updates the cached copy when the line is present, but it never installs a line. A flush input drops every line at once. On a miss, the block first fills empty entries, lowest number first. Once a bank is full, a free-running pseudo-random sequence picks the entry to replace.

Top module: `cam_cache`

## Requirements
- R1: After reset the block is idle (`req_ready`=1, `resp_valid`=0, `mem_req`=0), and `mem_req` stays low whenever `req_ready` is high.
- R2: Address bits [5:4] select one of four banks and bits [31:6] form the stored tag. Lines that differ only in those bank bits are cached side by side, and so are lines in the same bank that have different tags.
- R3: A read that hits returns the word selected by address bits [3:2] of the cached line, with `resp_hit`=1. `resp_valid` is high for one cycle, on the second rising edge after the edge that accepts the request.
- R4: A read miss issues four memory reads (`mem_we`=0) at addresses {addr[31:4], w, 2'b00} for w = 0, 1, 2, 3 in that order. It then returns the requested word with `resp_hit`=0, on the edge that takes the fourth acknowledge.
- R5: The privilege bit (`req_priv`, 1 = supervisor) is part of the match key. A line filled at one level misses at the other level.
- R6: On a miss, the new line goes into the lowest-numbered invalid entry of the selected bank. No valid line is replaced while any entry of that bank is invalid.
- R7: When all 64 entries of the bank are valid, a miss replaces exactly one entry, chosen by a free-running 6-bit LFSR.
- R8: Every store is sent to memory as one write (`mem_we`=1, `mem_addr` = request address) and answered on the edge that takes its acknowledge. A store that hits also updates the cached word and reports `resp_hit`=1.
- R9: A store that misses reports `resp_hit`=0 and installs no line, so a later read of that address misses.
- R10: A one-cycle `flush` pulse invalidates every entry of all banks by the next edge.
- R11: While `mem_req` is high and not yet acknowledged, `mem_req`, `mem_addr` and `mem_we` hold steady.
- R12: At most one entry of the addressed bank matches a lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Store data |
| req_priv | input | 1 | 1 = supervisor, 0 = user |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | Request hit in the cache |
| resp_rdata | output | 32 | Load data |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory accepts the transfer; read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
Counted in rising edges after the accepting edge, a read hit answers on edge 2. A store answers on the edge that takes its single memory acknowledge. With the bench memory acknowledging one cycle after each request, that is edge 2 for a store and edge 8 for a four-beat read miss. The bench accepts a request on one edge and counts the falling edges up to the one where `resp_valid` is first seen high. It checks that count against 3 for hits and stores and 9 for misses, and samples data, hit flag and the logged memory traffic at that point. Eviction is observed through the ports by probing lines with stores of unchanged data, because a store reports a hit without changing residency.

// File: rtl/cam_cache_pkg.sv
package cam_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_RDHIT,
    ST_FILL,
    ST_WRMEM
  } cc_state_e;
endpackage

// File: rtl/cam_lfsr.sv
// Free-running Fibonacci LFSR, taps for x^6 + x^5 + 1 at the default width.
module cam_lfsr #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] value
);
  logic [W-1:0] q;
  always_ff @(posedge clk) begin
    if (rst) q <= {{(W-1){1'b0}}, 1'b1};
    else     q <= {q[W-2:0], q[W-1] ^ q[W-2]};
  end
  assign value = q;
endmodule

// File: rtl/cam_bank.sv
// One content-addressed tag bank: per-entry comparators, hit and free encoders.
module cam_bank #(
  parameter int TAG_W      = 26,
  parameter int ENTRY_BITS = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic [TAG_W-1:0]      lkp_tag,
  input  logic                  lkp_priv,
  input  logic                  set_en,
  input  logic [ENTRY_BITS-1:0] set_idx,
  output logic [(1<<ENTRY_BITS)-1:0] match,
  output logic                  hit,
  output logic [ENTRY_BITS-1:0] hit_idx,
  output logic                  free_avail,
  output logic [ENTRY_BITS-1:0] free_idx,
  output logic [(1<<ENTRY_BITS)-1:0] valid_vec
);
  localparam int NENT = 1 << ENTRY_BITS;

  logic [TAG_W-1:0] tag_q  [NENT];
  logic             priv_q [NENT];
  logic [NENT-1:0]  valid_q;

  always_ff @(posedge clk) begin
    if (rst || flush) valid_q <= '0;
    else if (set_en)  valid_q[set_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (set_en) begin
      tag_q[set_idx]  <= lkp_tag;
      priv_q[set_idx] <= lkp_priv;
    end
  end

  for (genvar i = 0; i < NENT; i++) begin : g_cmp
    assign match[i] = valid_q[i] && (tag_q[i] == lkp_tag) && (priv_q[i] == lkp_priv);
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (match[i])    hit_idx  = ENTRY_BITS'(i);
      if (!valid_q[i]) free_idx = ENTRY_BITS'(i);
    end
  end

  assign hit        = |match;
  assign free_avail = ~&valid_q;
  assign valid_vec  = valid_q;
endmodule

// File: rtl/cam_dram.sv
// Single-port data RAM with registered read, written for block RAM inference.
module cam_dram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [1 << AW];
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/cam_cache.sv
module cam_cache
  import cam_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int BANK_BITS  = 2,
  parameter int ENTRY_BITS = 6,
  parameter int WORD_BITS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_priv,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int NBANK   = 1 << BANK_BITS;
  localparam int NENT    = 1 << ENTRY_BITS;
  localparam int WORD_LO = 2;
  localparam int BANK_LO = WORD_LO + WORD_BITS;
  localparam int TAG_LO  = BANK_LO + BANK_BITS;
  localparam int TAG_W   = ADDR_W - TAG_LO;
  localparam int RAM_AW  = BANK_BITS + ENTRY_BITS + WORD_BITS;
  localparam logic [WORD_BITS-1:0] LAST_BEAT = '1;

  cc_state_e state;
  logic [ADDR_W-1:0]     r_addr;
  logic [DATA_W-1:0]     r_wdata;
  logic                  r_we, r_priv;
  logic [WORD_BITS-1:0]  beat;
  logic [ENTRY_BITS-1:0] fill_idx;
  logic [DATA_W-1:0]     keep_word;

  logic [BANK_BITS-1:0]  r_bank;
  logic [WORD_BITS-1:0]  r_word;
  logic [TAG_W-1:0]      r_tag;
  assign r_bank = r_addr[TAG_LO-1:BANK_LO];
  assign r_word = r_addr[BANK_LO-1:WORD_LO];
  assign r_tag  = r_addr[ADDR_W-1:TAG_LO];

  // Per-bank tag stores
  logic [NENT-1:0]       match_b [NBANK];
  logic [NENT-1:0]       valid_b [NBANK];
  logic                  hit_b   [NBANK];
  logic                  avail_b [NBANK];
  logic [ENTRY_BITS-1:0] hidx_b  [NBANK];
  logic [ENTRY_BITS-1:0] fidx_b  [NBANK];
  logic [NBANK*NENT-1:0] valid_all;
  logic                  fill_last;

  assign fill_last = (state == ST_FILL) && mem_ack && (beat == LAST_BEAT);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    cam_bank #(.TAG_W(TAG_W), .ENTRY_BITS(ENTRY_BITS)) u_bank (
      .clk        (clk),
      .rst        (rst),
      .flush      (flush),
      .lkp_tag    (r_tag),
      .lkp_priv   (r_priv),
      .set_en     (fill_last && (r_bank == BANK_BITS'(g))),
      .set_idx    (fill_idx),
      .match      (match_b[g]),
      .hit        (hit_b[g]),
      .hit_idx    (hidx_b[g]),
      .free_avail (avail_b[g]),
      .free_idx   (fidx_b[g]),
      .valid_vec  (valid_b[g])
    );
    assign valid_all[g*NENT +: NENT] = valid_b[g];
  end

  logic                  sel_hit, sel_avail;
  logic [ENTRY_BITS-1:0] sel_hidx, sel_fidx;
  logic [NENT-1:0]       sel_match;
  assign sel_hit   = hit_b[r_bank];
  assign sel_avail = avail_b[r_bank];
  assign sel_hidx  = hidx_b[r_bank];
  assign sel_fidx  = fidx_b[r_bank];
  assign sel_match = match_b[r_bank];

  logic [ENTRY_BITS-1:0] rnd;
  cam_lfsr #(.W(ENTRY_BITS)) u_lfsr (.clk(clk), .rst(rst), .value(rnd));

  // Data RAM port
  logic              ram_en, ram_we;
  logic [RAM_AW-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata, ram_q;

  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = '0;
    ram_wdata = r_wdata;
    if (state == ST_LOOK && sel_hit) begin
      ram_en   = 1'b1;
      ram_we   = r_we;
      ram_addr = {r_bank, sel_hidx, r_word};
    end else if (state == ST_FILL && mem_ack) begin
      ram_en    = 1'b1;
      ram_we    = 1'b1;
      ram_addr  = {r_bank, fill_idx, beat};
      ram_wdata = mem_rdata;
    end
  end

  cam_dram #(.AW(RAM_AW), .DW(DATA_W)) u_dram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_q)
  );

  // Control
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      r_addr     <= '0;
      r_wdata    <= '0;
      r_we       <= 1'b0;
      r_priv     <= 1'b0;
      beat       <= '0;
      fill_idx   <= '0;
      keep_word  <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          r_addr  <= req_addr;
          r_wdata <= req_wdata;
          r_we    <= req_we;
          r_priv  <= req_priv;
          state   <= ST_LOOK;
        end
        ST_LOOK: begin
          resp_hit <= sel_hit;
          beat     <= '0;
          fill_idx <= sel_avail ? sel_fidx : rnd;
          if (r_we)         state <= ST_WRMEM;
          else if (sel_hit) state <= ST_RDHIT;
          else              state <= ST_FILL;
        end
        ST_RDHIT: begin
          resp_valid <= 1'b1;
          resp_rdata <= ram_q;
          state      <= ST_IDLE;
        end
        ST_FILL: if (mem_ack) begin
          beat <= beat + 1'b1;
          if (beat == r_word) keep_word <= mem_rdata;
          if (beat == LAST_BEAT) begin
            resp_valid <= 1'b1;
            resp_rdata <= (r_word == LAST_BEAT) ? mem_rdata : keep_word;
            state      <= ST_IDLE;
          end
        end
        ST_WRMEM: if (mem_ack) begin
          resp_valid <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign mem_req   = (state == ST_FILL) || (state == ST_WRMEM);
  assign mem_we    = (state == ST_WRMEM);
  assign mem_wdata = r_wdata;
  assign mem_addr  = (state == ST_FILL) ? {r_addr[ADDR_W-1:BANK_LO], beat, 2'b00} : r_addr;
endmodule

// File: rtl/cam_cache_chk.sv
module cam_cache_chk #(
  parameter int NE = 64,
  parameter int NB = 4,
  parameter int AW = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           flush,
  input logic           req_ready,
  input logic           resp_valid,
  input logic           mem_req,
  input logic           mem_we,
  input logic           mem_ack,
  input logic [AW-1:0]  mem_addr,
  input logic [NE-1:0]  sel_match,
  input logic [NB*NE-1:0] valid_all
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req);

  assert_resp_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  assert_flush_clear_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_all == '0));

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_single_match_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_match));
endmodule

bind cam_cache cam_cache_chk #(.NE(NENT), .NB(NBANK), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .req_ready(req_ready),
  .resp_valid(resp_valid), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .sel_match(sel_match),
  .valid_all(valid_all)
);

// File: tb/cam_cache_bench.sv
`timescale 1ns/1ps
module cam_cache_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_priv = 1'b1;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, resp_valid, resp_hit;
  logic [31:0] resp_rdata;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  cam_cache u_cam_cache (
    .clk(clk), .rst(rst), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_priv(req_priv),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // Reference memory, one acknowledge per request one cycle after it appears
  logic [31:0] ref_mem [1024];
  logic [31:0] rd_log  [8];
  int rd_cnt = 0;
  int wr_cnt = 0;

  initial for (int i = 0; i < 1024; i++) ref_mem[i] = 32'hC0DE_0000 ^ (i * 32'h0001_0103);

  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        ref_mem[mem_addr[11:2]] = mem_wdata;
        wr_cnt++;
      end else begin
        mem_rdata = ref_mem[mem_addr[11:2]];
        if (rd_cnt < 8) rd_log[rd_cnt] = mem_addr;
        rd_cnt++;
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] r_data;
  logic r_hit;
  int r_lat;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd, input bit priv);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd; req_priv = priv;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 1;
    while (!resp_valid && r_lat < 60) begin
      @(negedge clk);
      r_lat++;
    end
    r_data = resp_rdata;
    r_hit  = resp_hit;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  function automatic logic [31:0] mexp(input logic [31:0] a);
    return ref_mem[a[11:2]];
  endfunction

  task automatic t_reset();
    check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
    check(resp_valid == 1'b0, "R1 resp", 32'(resp_valid), 0);
    check(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 0);
  endtask

  task automatic t_fill_and_hit();
    logic [31:0] a = 32'h0000_0104;
    rd_cnt = 0;
    access(1'b0, a, '0, 1'b1);
    check(r_hit == 1'b0, "R4 miss flag", 32'(r_hit), 0);
    check(r_data == mexp(a), "R4 fill data", r_data, mexp(a));
    check(r_lat == 9, "R4 miss latency", r_lat, 9);
    check(rd_cnt == 4, "R4 beat count", rd_cnt, 4);
    for (int w = 0; w < 4; w++)
      check(rd_log[w] == {a[31:4], 2'(w), 2'b00}, "R4 beat order", rd_log[w], {a[31:4], 2'(w), 2'b00});
    for (int w = 0; w < 4; w++) begin
      logic [31:0] aw = {a[31:4], 2'(w), 2'b00};
      access(1'b0, aw, '0, 1'b1);
      check(r_hit == 1'b1, "R3 hit flag", 32'(r_hit), 1);
      check(r_data == mexp(aw), "R3 hit data", r_data, mexp(aw));
      check(r_lat == 3, "R3 hit latency", r_lat, 3);
    end
  endtask

  task automatic t_banks();
    access(1'b0, 32'h0000_0114, '0, 1'b1);
    check(r_hit == 1'b0, "R2 other bank miss", 32'(r_hit), 0);
    access(1'b0, 32'h0001_0104, '0, 1'b1);
    check(r_hit == 1'b0, "R2 other tag miss", 32'(r_hit), 0);
    access(1'b0, 32'h0000_0104, '0, 1'b1);
    check(r_hit == 1'b1, "R2 first line kept", 32'(r_hit), 1);
    access(1'b0, 32'h0000_0114, '0, 1'b1);
    check(r_hit == 1'b1 && r_data == mexp(32'h114), "R2 bank1 line", r_data, mexp(32'h114));
    access(1'b0, 32'h0001_0104, '0, 1'b1);
    check(r_hit == 1'b1 && r_data == mexp(32'h0001_0104), "R2 tag2 line", r_data, mexp(32'h0001_0104));
  endtask

  task automatic t_priv();
    access(1'b0, 32'h0000_0104, '0, 1'b0);
    check(r_hit == 1'b0, "R5 user misses", 32'(r_hit), 0);
    access(1'b0, 32'h0000_0104, '0, 1'b0);
    check(r_hit == 1'b1, "R5 user now hits", 32'(r_hit), 1);
    access(1'b0, 32'h0000_0108, '0, 1'b1);
    // R12: both privilege copies present, single entry matches
    check(r_hit == 1'b1 && r_data == mexp(32'h108), "R12 super copy", r_data, mexp(32'h108));
  endtask

  task automatic t_write();
    int w0 = wr_cnt;
    access(1'b1, 32'h0000_0108, 32'hFEED_0001, 1'b1);
    check(r_hit == 1'b1, "R8 store hit", 32'(r_hit), 1);
    check(r_lat == 3, "R8 store latency", r_lat, 3);
    check(wr_cnt == w0 + 1 && mexp(32'h108) == 32'hFEED_0001, "R8 forwarded", mexp(32'h108), 32'hFEED_0001);
    ref_mem[32'h108 >> 2] = 32'h0BAD_0BAD;
    access(1'b0, 32'h0000_0108, '0, 1'b1);
    check(r_hit == 1'b1 && r_data == 32'hFEED_0001, "R8 cache updated", r_data, 32'hFEED_0001);
    access(1'b1, 32'h0000_2000, 32'hABCD_1234, 1'b1);
    check(r_hit == 1'b0, "R9 store miss", 32'(r_hit), 0);
    check(mexp(32'h2000) == 32'hABCD_1234, "R9 forwarded", mexp(32'h2000), 32'hABCD_1234);
    access(1'b0, 32'h0000_2000, '0, 1'b1);
    check(r_hit == 1'b0, "R9 no allocate", 32'(r_hit), 0);
    check(r_data == 32'hABCD_1234, "R9 read data", r_data, 32'hABCD_1234);
  endtask

  task automatic t_flush();
    pulse_flush();
    access(1'b0, 32'h0000_0114, '0, 1'b1);
    check(r_hit == 1'b0, "R10 flushed line misses", 32'(r_hit), 0);
  endtask

  function automatic logic [31:0] fa(input int k);
    return 32'h0001_0020 + k * 64;
  endfunction

  task automatic t_fill_order_and_evict();
    int h = 0;
    pulse_flush();
    for (int k = 0; k < 64; k++) begin
      access(1'b0, fa(k), '0, 1'b1);
      if (!r_hit) h++;
    end
    check(h == 64, "R6 first pass misses", h, 64);
    h = 0;
    for (int k = 0; k < 64; k++) begin
      access(1'b0, fa(k), '0, 1'b1);
      if (r_hit && r_data == mexp(fa(k))) h++;
    end
    check(h == 64, "R6 all lines resident", h, 64);
    access(1'b0, fa(64), '0, 1'b1);
    check(r_hit == 1'b0 && r_data == mexp(fa(64)), "R7 full-bank miss", r_data, mexp(fa(64)));
    access(1'b0, fa(64), '0, 1'b1);
    check(r_hit == 1'b1, "R7 new line resident", 32'(r_hit), 1);
    h = 0;
    for (int k = 0; k < 64; k++) begin
      access(1'b1, fa(k), mexp(fa(k)), 1'b1);
      if (r_hit) h++;
    end
    check(h == 63, "R7 exactly one evicted", h, 63);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill_and_hit();
    t_banks();
    t_priv();
    t_write();
    t_flush();
    t_fill_order_and_evict();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule